// File: doc/BRIEF.md
# Banked Interrupt Collector with Sticky Status

This block gathers peripheral interrupt request lines into a number of banks, each holding `SRC_W` lines (32 by default). Every bank latches requests into a sticky pending register, which software clears by writing ones. An enable register selects which pending bits may reach the CPU. The pending bits ANDed with the enable bits form an output-status word. Software can read that word, and the OR of it, registered once, drives the bank's request line. The bank also reports the position of the most significant set bit of its output status, so the handler can find the winning source without scanning.

Software reaches the registers through a plain 32-bit read/write port with byte addresses. Inside each bank, the offsets are: pending status 0x00, enable 0x08, output status 0x10 (read-only), resend 0x18 and mask 0x20. Bank n starts at byte address n*0x28. The port has no back-pressure. A write is taken on every cycle where `wr_en` is high. A read is taken on every cycle where `rd_en` is high, and its data appears on `rdata` one cycle later.

To bring the block up, software disables every source, writes all-ones to status and mask, and clears resend. Enabling or disabling one source is a read-modify-write of the enable word.

Top module: `irq_bank_ctrl`

## Requirements
- R1: A pending bit is set after any clock edge at which its input line is high. When a line is high in the same cycle that a write of 1 clears its bit, the bit stays set.
- R2: A write to offset 0x00 clears every pending bit whose write-data bit is 1 and whose line is low. Bits written with 0 keep their value.
- R3: A read of offset 0x10 returns the pending bits ANDed with the enable bits. Writes to 0x10 change no register.
- R4: A bank's request output is 1 exactly one cycle after its output status is nonzero, and is 0 one cycle after the output status is zero.
- R5: A write to offset 0x08 replaces the whole enable word, and the enable word reads back unchanged until the next such write.
- R6: Writes to offsets 0x18 (resend) and 0x20 (mask) store all 32 bits, which read back unchanged. Neither register affects pending, output status or requests.
- R7: `src_vld` of a bank is 1 exactly when its output status is nonzero. `src_idx` of the bank is then the bit position of the most significant set output-status bit, from 0 to 31.
- R8: Bank n's registers sit at byte address n*0x28 plus their offset, and an access to one bank never changes another bank.
- R9: A read of an unmapped address returns 0, and a write to one changes no register. Unmapped addresses are offsets other than the five above, and addresses at or beyond NUM_BANKS*0x28.
- R10: After reset, every register reads 0, and every request and `src_vld` is 0.
- R11: With all lines low, the bring-up writes (enable 0, status all-ones, mask all-ones, resend 0) leave status, output status, request and `src_vld` at 0, and mask reads all-ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NUM_BANKS*SRC_W | Request lines, bank b line i at bit b*SRC_W+i |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte address |
| wdata | input | SRC_W | Write data |
| rdata | output | SRC_W | Read data, valid the cycle after rd_en |
| irq_req | output | NUM_BANKS | Registered request per bank |
| src_idx | output | NUM_BANKS*IDX_W | Highest set output-status bit per bank |
| src_vld | output | NUM_BANKS | Bank has a nonzero output status |

## Verification
A single line is walked across every position of both banks. This pattern shows whether each line sets its own pending bit, whether a write of one clears only that bit, and whether banks stay separate.

For the index, the walked bit is combined with set bits below it. This separates a true most-significant-bit search from a lowest-bit or any-bit search.

Enable is tried with all-ones, all-zeros and alternating words, which exposes a missing AND in the output status and a missing request gate. A line held high during a clearing write, and writes to read-only and unmapped addresses, check the set-over-clear priority and the ignore rules.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;
  localparam int OFF_STAT = 'h00;
  localparam int OFF_EN   = 'h08;
  localparam int OFF_OUT  = 'h10;
  localparam int OFF_RSND = 'h18;
  localparam int OFF_MASK = 'h20;

  typedef enum logic [2:0] {
    RS_NONE,
    RS_STAT,
    RS_EN,
    RS_OUT,
    RS_RSND,
    RS_MASK
  } reg_sel_e;
endpackage

// File: rtl/irq_addr_dec.sv
module irq_addr_dec
  import irq_bank_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int NUM_BANKS = 2,
  parameter int STRIDE    = 'h28,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [BANK_W-1:0] bank,
  output reg_sel_e          sel,
  output logic              hit
);
  logic [ADDR_W-1:0] quot;
  logic [ADDR_W-1:0] offs;
  logic              in_range;

  always_comb begin
    quot     = addr / ADDR_W'(STRIDE);
    offs     = addr % ADDR_W'(STRIDE);
    in_range = (quot < ADDR_W'(NUM_BANKS));
    bank     = quot[BANK_W-1:0];
    sel      = RS_NONE;
    if (in_range) begin
      if      (offs == ADDR_W'(OFF_STAT)) sel = RS_STAT;
      else if (offs == ADDR_W'(OFF_EN))   sel = RS_EN;
      else if (offs == ADDR_W'(OFF_OUT))  sel = RS_OUT;
      else if (offs == ADDR_W'(OFF_RSND)) sel = RS_RSND;
      else if (offs == ADDR_W'(OFF_MASK)) sel = RS_MASK;
    end
    hit = (sel != RS_NONE);
  end
endmodule

// File: rtl/irq_msb_find.sv
module irq_msb_find #(
  parameter int W      = 32,
  localparam int IDX_W = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]     vec,
  output logic [IDX_W-1:0] idx,
  output logic             vld
);
  always_comb begin
    idx = '0;
    for (int i = 0; i < W; i++) begin
      if (vec[i]) idx = IDX_W'(i);
    end
    vld = |vec;
  end
endmodule

// File: rtl/irq_bank.sv
module irq_bank #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lines,
  input  logic [W-1:0] wdata,
  input  logic         wr_stat,
  input  logic         wr_enab,
  input  logic         wr_rsnd,
  input  logic         wr_mask,
  output logic [W-1:0] pend,
  output logic [W-1:0] enab,
  output logic [W-1:0] rsnd,
  output logic [W-1:0] mreg,
  output logic [W-1:0] outst,
  output logic         req
);
  logic [W-1:0] clr_bits;

  assign clr_bits = wr_stat ? wdata : '0;
  assign outst    = pend & enab;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0;
      enab <= '0;
      rsnd <= '0;
      mreg <= '0;
      req  <= 1'b0;
    end else begin
      pend <= (pend & ~clr_bits) | lines;
      if (wr_enab) enab <= wdata;
      if (wr_rsnd) rsnd <= wdata;
      if (wr_mask) mreg <= wdata;
      req <= |outst;
    end
  end

  a_r1_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((pend & $past(lines)) == $past(lines)));

  a_r2_clear_only_ones: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((pend & $past(clr_bits & ~lines)) == '0));

  a_r2_others_kept: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((pend & ~$past(clr_bits | lines)) ==
                      ($past(pend) & ~$past(clr_bits | lines))));

  a_r4_req_follows: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (req == (|$past(outst))));

  a_r5_enab_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(wr_enab)) |-> $stable(enab));
endmodule

// File: rtl/irq_bank_ctrl.sv
module irq_bank_ctrl
  import irq_bank_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int SRC_W     = 32,
  parameter int ADDR_W    = 8,
  parameter int STRIDE    = 'h28,
  localparam int IDX_W    = (SRC_W > 1) ? $clog2(SRC_W) : 1,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_BANKS*SRC_W-1:0] irq_in,
  input  logic                       wr_en,
  input  logic                       rd_en,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [SRC_W-1:0]           wdata,
  output logic [SRC_W-1:0]           rdata,
  output logic [NUM_BANKS-1:0]       irq_req,
  output logic [NUM_BANKS*IDX_W-1:0] src_idx,
  output logic [NUM_BANKS-1:0]       src_vld
);
  logic [BANK_W-1:0] bank;
  reg_sel_e          sel;
  logic              hit;

  logic [SRC_W-1:0] pend_a [NUM_BANKS];
  logic [SRC_W-1:0] enab_a [NUM_BANKS];
  logic [SRC_W-1:0] rsnd_a [NUM_BANKS];
  logic [SRC_W-1:0] mreg_a [NUM_BANKS];
  logic [SRC_W-1:0] outs_a [NUM_BANKS];
  logic [SRC_W-1:0] rd_mux;

  irq_addr_dec #(
    .ADDR_W   (ADDR_W),
    .NUM_BANKS(NUM_BANKS),
    .STRIDE   (STRIDE)
  ) u_dec (
    .addr(addr),
    .bank(bank),
    .sel (sel),
    .hit (hit)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic mine;
    assign mine = wr_en && hit && (bank == BANK_W'(b));

    irq_bank #(.W(SRC_W)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .lines  (irq_in[b*SRC_W +: SRC_W]),
      .wdata  (wdata),
      .wr_stat(mine && (sel == RS_STAT)),
      .wr_enab(mine && (sel == RS_EN)),
      .wr_rsnd(mine && (sel == RS_RSND)),
      .wr_mask(mine && (sel == RS_MASK)),
      .pend   (pend_a[b]),
      .enab   (enab_a[b]),
      .rsnd   (rsnd_a[b]),
      .mreg   (mreg_a[b]),
      .outst  (outs_a[b]),
      .req    (irq_req[b])
    );

    irq_msb_find #(.W(SRC_W)) u_msb (
      .vec(outs_a[b]),
      .idx(src_idx[b*IDX_W +: IDX_W]),
      .vld(src_vld[b])
    );

    a_r7_msb_index: assert property (@(posedge clk) disable iff (!rst_n)
      src_vld[b] |-> ((outs_a[b] >> src_idx[b*IDX_W +: IDX_W]) == SRC_W'(1)));
  end

  always_comb begin
    rd_mux = '0;
    if (hit) begin
      case (sel)
        RS_STAT: rd_mux = pend_a[bank];
        RS_EN:   rd_mux = enab_a[bank];
        RS_OUT:  rd_mux = outs_a[bank];
        RS_RSND: rd_mux = rsnd_a[bank];
        RS_MASK: rd_mux = mreg_a[bank];
        default: rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(rd_en) && !$past(hit)) |-> (rdata == '0));
endmodule

// File: tb/irq_bank_ctrl_test.sv
`timescale 1ns/100ps
module irq_bank_ctrl_test;
  localparam int NB = 2;
  localparam int W  = 32;
  localparam int IW = 5;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NB*W-1:0] irq_in = '0;
  logic            wr_en = 1'b0;
  logic            rd_en = 1'b0;
  logic [7:0]      addr = '0;
  logic [W-1:0]    wdata = '0;
  logic [W-1:0]    rdata;
  logic [NB-1:0]   irq_req;
  logic [NB*IW-1:0] src_idx;
  logic [NB-1:0]   src_vld;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  irq_bank_ctrl uut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_req(irq_req),
    .src_idx(src_idx), .src_vld(src_vld)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [W-1:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [W-1:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic pulse(input int b, input logic [W-1:0] v);
    @(negedge clk); irq_in[b*W +: W] = v;
    @(negedge clk); irq_in = '0;
  endtask

  function automatic logic [7:0] ra(input int b, input int off);
    return 8'(b * 'h28 + off);
  endfunction

  function automatic int msb(input logic [W-1:0] v);
    int r = -1;
    for (int i = 0; i < W; i++) if (v[i]) r = i;
    return r;
  endfunction

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [W-1:0] d;
    logic [W-1:0] ens [3];
    ens[0] = '1; ens[1] = '0; ens[2] = 32'hAAAA_5555;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    for (int b = 0; b < NB; b++) begin
      for (int o = 0; o <= 'h20; o += 8) begin
        rd(ra(b, o), d); chk("R10 reg after reset", d, '0);
      end
    end
    chk("R10 req/vld after reset", {30'd0, irq_req}, '0);
    chk("R10 vld after reset", {30'd0, src_vld}, '0);

    // R1/R2/R8 walking single line in each bank
    for (int b = 0; b < NB; b++) begin
      for (int i = 0; i < W; i++) begin
        pulse(b, 32'(1) << i);
        rd(ra(b, 'h00), d); chk("R1 line sets pending", d, 32'(1) << i);
        rd(ra(1 - b, 'h00), d); chk("R8 other bank untouched", d, '0);
        wr(ra(b, 'h00), 32'(1) << i);
        rd(ra(b, 'h00), d); chk("R2 write one clears", d, '0);
      end
    end

    // R2 zeros keep their bits
    pulse(0, 32'hF0F0_1234);
    wr(ra(0, 'h00), 32'h00F0_0004);
    rd(ra(0, 'h00), d); chk("R2 zero bits kept", d, 32'hF000_1230);
    wr(ra(0, 'h00), '1);

    // R1 set wins over same-cycle clear
    @(negedge clk); irq_in[7] = 1'b1; wr_en = 1'b1; addr = ra(0, 'h00); wdata = 32'h80;
    @(negedge clk); irq_in = '0; wr_en = 1'b0;
    rd(ra(0, 'h00), d); chk("R1 set beats clear", d, 32'h80);
    wr(ra(0, 'h00), '1);

    // R3/R5/R4 enable patterns
    for (int k = 0; k < 3; k++) begin
      wr(ra(1, 'h08), ens[k]);
      rd(ra(1, 'h08), d); chk("R5 enable readback", d, ens[k]);
      pulse(1, 32'h1234_F00F);
      rd(ra(1, 'h10), d); chk("R3 out = pend & en", d, 32'h1234_F00F & ens[k]);
      chk("R4 req level", {31'd0, irq_req[1]}, {31'd0, |(32'h1234_F00F & ens[k])});
      wr(ra(1, 'h10), '1);
      rd(ra(1, 'h00), d); chk("R3 write to out ignored", d, 32'h1234_F00F);
      wr(ra(1, 'h00), '1);
      @(negedge clk);
      chk("R4 req drops", {31'd0, irq_req[1]}, '0);
    end

    // R4 exact latency
    wr(ra(0, 'h08), '1);
    @(negedge clk); irq_in[3] = 1'b1;
    @(negedge clk); irq_in = '0;
    chk("R4 req not yet", {31'd0, irq_req[0]}, '0);
    @(negedge clk);
    chk("R4 req after one cycle", {31'd0, irq_req[0]}, 32'd1);
    wr(ra(0, 'h00), '1);

    // R7 index sweep with lower filler bits
    for (int i = 0; i < W; i++) begin
      logic [W-1:0] v;
      v = (32'(1) << i) | ((32'h5A5A_5A5A) & ((32'(1) << i) - 1));
      pulse(0, v);
      chk("R7 index", 32'(src_idx[IW-1:0]), 32'(msb(v)));
      chk("R7 valid", {31'd0, src_vld[0]}, 32'd1);
      wr(ra(0, 'h00), '1);
      chk("R7 valid clears", {31'd0, src_vld[0]}, '0);
    end
    wr(ra(0, 'h08), 32'h0000_00FF);
    pulse(0, 32'h8000_0010);
    chk("R7 masked-off msb ignored", 32'(src_idx[IW-1:0]), 32'd4);
    wr(ra(0, 'h00), '1);

    // R6 resend and mask storage
    wr(ra(1, 'h18), 32'hDEAD_BEEF);
    wr(ra(1, 'h20), 32'h0BAD_F00D);
    rd(ra(1, 'h18), d); chk("R6 resend readback", d, 32'hDEAD_BEEF);
    rd(ra(1, 'h20), d); chk("R6 mask readback", d, 32'h0BAD_F00D);
    rd(ra(1, 'h00), d); chk("R6 no effect on pending", d, '0);

    // R9 unmapped accesses
    wr(8'h04, '1);
    wr(8'h50, '1);
    wr(8'h2C, '1);
    rd(8'h04, d); chk("R9 unmapped read", d, '0);
    rd(8'h50, d); chk("R9 beyond banks read", d, '0);
    rd(ra(0, 'h08), d); chk("R9 enable unchanged", d, 32'h0000_00FF);
    rd(ra(1, 'h08), d); chk("R9 bank1 enable unchanged", d, ens[2]);
    rd(ra(1, 'h18), d); chk("R9 resend unchanged", d, 32'hDEAD_BEEF);

    // R11 bring-up sequence
    for (int b = 0; b < NB; b++) begin
      pulse(b, 32'hFFFF_0001);
      wr(ra(b, 'h08), '0);
      wr(ra(b, 'h00), '1);
      wr(ra(b, 'h20), '1);
      wr(ra(b, 'h18), '0);
      rd(ra(b, 'h00), d); chk("R11 nothing pending", d, '0);
      rd(ra(b, 'h10), d); chk("R11 out status zero", d, '0);
      rd(ra(b, 'h20), d); chk("R11 mask all ones", d, '1);
      chk("R11 req low", {31'd0, irq_req[b]}, '0);
      chk("R11 vld low", {31'd0, src_vld[b]}, '0);
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule